// File: doc/BRIEF.md
# Memory-Mapped Command Channel for a Power-Management Bus Master

This block is a software-facing command channel placed in front of the master of a serial power-management bus. Software sees five word registers: a status word, a write-data word, a read-data word, a command word and a valid-clear word. To start a transfer, software polls the status word until the channel reports idle. For a write, it loads the write-data word first. It then writes one 32-bit command word that packs the command class, the direction, the target slave ID, the byte count and the register address.

Once the command word is written, the channel offers a decoded request to the bus-side master on a valid/ready handshake. A write finishes when that handshake completes. A read then waits for a response strobe and captures the returned data, trimmed to the requested byte count. The channel then stays busy until software writes the valid-clear word. A command written at the wrong moment, or one that is malformed, is dropped, and a sticky error flag in the status word records it.

Register word indices on `csr_addr`: 0 status, 1 write data, 2 read data, 3 command, 4 valid clear. Reads are combinational from `csr_addr`. Unmapped indices and the command index read as zero.

Top module: `cmdch_top`

## Requirements
- R1: After reset the status word reads 0. Status bits [3:1] hold the channel state: 0 idle, 1 request offered to the bus, 2 read awaiting response, 6 read data valid and awaiting clear. Bit 4 is the sticky error flag. No other state code ever appears.
- R2: A legal command word written while idle raises `bus_req_valid` on the next cycle, with class = bits [31:30], write = bit 29, slave ID = bits [27:24], byte count minus one = bits [17:16] and address = bits [15:0]. The valid signal and every request field hold steady until `bus_req_ready` is seen.
- R3: For a write command (bit 29 set), the cycle after the handshake completes the state is idle again, with no valid-clear step.
- R4: For a read command, the state moves to 2 after the handshake. A `bus_rsp_valid` pulse then moves it to 6 and loads the read-data word.
- R5: Read data keeps only the requested number of bytes, least significant byte first. Higher bytes read as zero.
- R6: `bus_req_wdata` is the write-data word as it stood when the command word was written, trimmed to the byte count. Later writes to the write-data word do not change it.
- R7: Writing the valid-clear word with bit 0 set while the state is 6 returns the channel to idle. This releases a read that software has abandoned. Writing it in any other state, or with bit 0 clear, has no effect.
- R8: A command word written while the state is not idle is ignored: the request fields and the state are unaffected. The sticky error flag is set.
- R9: A command word with class 2, or with any of bits 28 or [23:18] set, is rejected while idle. No request is raised, and the error flag is set.
- R10: Writing the status word with bit 4 set clears the error flag. Otherwise the flag stays set.
- R11: A `bus_rsp_valid` pulse outside state 2 changes neither the state nor the read-data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 3 | Register word index for write and read |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data for `csr_addr` (combinational) |
| bus_req_valid | output | 1 | Request offered to the bus master |
| bus_req_ready | input | 1 | Bus master accepts the request |
| bus_req_cls | output | 2 | Command class |
| bus_req_write | output | 1 | 1 for write, 0 for read |
| bus_req_sid | output | 4 | Target slave ID |
| bus_req_len | output | 2 | Byte count minus one |
| bus_req_addr | output | 16 | Target register address |
| bus_req_wdata | output | 32 | Write data, trimmed to the byte count |
| bus_rsp_valid | input | 1 | Read response strobe |
| bus_rsp_rdata | input | 32 | Read response data |

## Verification
Every state change is registered once. A command, handshake, response or clear accepted at one rising edge is therefore visible on the status word and the request outputs from that edge onward, one cycle after the stimulus was driven. The read-data word and `bus_req_wdata` also settle on that same edge, because trimming is done before the capture register. The bench drives inputs on falling edges and samples on the next falling edge, half a cycle after the edge that should have acted. Status is read combinationally through `csr_addr` at that point.

// File: rtl/cmdch_pkg.sv
package cmdch_pkg;
    parameter int DATA_W  = 32;
    parameter int NBYTES  = DATA_W / 8;
    parameter int LEN_W   = $clog2(NBYTES);
    parameter int SID_W   = 4;
    parameter int RADDR_W = 16;
    parameter int CLS_W   = 2;
    parameter int IDX_W   = 3;
    parameter int ST_W    = 3;

    localparam logic [IDX_W-1:0] IDX_STATUS = 3'd0;
    localparam logic [IDX_W-1:0] IDX_WDATA  = 3'd1;
    localparam logic [IDX_W-1:0] IDX_RDATA  = 3'd2;
    localparam logic [IDX_W-1:0] IDX_CMD    = 3'd3;
    localparam logic [IDX_W-1:0] IDX_VCLR   = 3'd4;

    localparam int CMD_CLS_LSB  = 30;
    localparam int CMD_WR_BIT   = 29;
    localparam int CMD_RSV_HI   = 28;
    localparam int CMD_SID_LSB  = 24;
    localparam int CMD_RSV_LSB  = 18;
    localparam int CMD_RSV_W    = 6;
    localparam int CMD_LEN_LSB  = 16;
    localparam int CMD_ADDR_LSB = 0;

    localparam int STS_ST_LSB  = 1;
    localparam int STS_ERR_BIT = 4;

    localparam logic [CLS_W-1:0] CLS_RSVD = 2'd2;

    typedef enum logic [ST_W-1:0] {
        ST_IDLE  = 3'd0,
        ST_ISSUE = 3'd1,
        ST_AWAIT = 3'd2,
        ST_HOLD  = 3'd6
    } chan_state_e;

    typedef struct packed {
        logic [CLS_W-1:0]   cls;
        logic               wr;
        logic [SID_W-1:0]   sid;
        logic [LEN_W-1:0]   len_m1;
        logic [RADDR_W-1:0] addr;
    } cmd_t;

    typedef struct packed {
        chan_state_e       st;
        logic              err;
        cmd_t              cmd;
        logic [DATA_W-1:0] wd;
        logic [DATA_W-1:0] rd;
    } chan_regs_t;
endpackage

// File: rtl/cmdch_unpack.sv
module cmdch_unpack
    import cmdch_pkg::*;
(
    input  logic [DATA_W-1:0] word,
    output cmd_t              cmd,
    output logic              legal
);
    logic rsv_set;

    always_comb begin
        cmd.cls    = word[CMD_CLS_LSB +: CLS_W];
        cmd.wr     = word[CMD_WR_BIT];
        cmd.sid    = word[CMD_SID_LSB +: SID_W];
        cmd.len_m1 = word[CMD_LEN_LSB +: LEN_W];
        cmd.addr   = word[CMD_ADDR_LSB +: RADDR_W];
        rsv_set    = word[CMD_RSV_HI] | (|word[CMD_RSV_LSB +: CMD_RSV_W]);
        legal      = (cmd.cls != CLS_RSVD) && !rsv_set;
    end
endmodule

// File: rtl/cmdch_byte_mask.sv
module cmdch_byte_mask
    import cmdch_pkg::*;
(
    input  logic [DATA_W-1:0] din,
    input  logic [LEN_W-1:0]  len_m1,
    output logic [DATA_W-1:0] dout
);
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign dout[b*8 +: 8] = (len_m1 >= LEN_W'(b)) ? din[b*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/cmdch_fsm.sv
module cmdch_fsm
    import cmdch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_fire,
    input  cmd_t              cmd_in,
    input  logic              cmd_legal,
    input  logic [DATA_W-1:0] wd_in,
    input  logic              vclr_fire,
    input  logic              err_clr,
    input  logic              req_ready,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_data,
    output chan_state_e       state,
    output logic              err,
    output logic              req_valid,
    output cmd_t              req_cmd,
    output logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_data
);
    chan_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (err_clr) begin
            r_d.err = 1'b0;
        end
        unique case (r_q.st)
            ST_IDLE: begin
                if (cmd_fire) begin
                    if (cmd_legal) begin
                        r_d.st  = ST_ISSUE;
                        r_d.cmd = cmd_in;
                        r_d.wd  = wd_in;
                    end else begin
                        r_d.err = 1'b1;
                    end
                end
            end
            ST_ISSUE: begin
                if (req_ready) begin
                    r_d.st = r_q.cmd.wr ? ST_IDLE : ST_AWAIT;
                end
            end
            ST_AWAIT: begin
                if (rsp_valid) begin
                    r_d.st = ST_HOLD;
                    r_d.rd = rsp_data;
                end
            end
            ST_HOLD: begin
                if (vclr_fire) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
        if (cmd_fire && (r_q.st != ST_IDLE)) begin
            r_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, err: 1'b0, cmd: '0, wd: '0, rd: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign state     = r_q.st;
    assign err       = r_q.err;
    assign req_valid = (r_q.st == ST_ISSUE);
    assign req_cmd   = r_q.cmd;
    assign req_wdata = r_q.wd;
    assign rd_data   = r_q.rd;

    p_state_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.st inside {ST_IDLE, ST_ISSUE, ST_AWAIT, ST_HOLD});

    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_cmd) && $stable(req_wdata)));

    p_write_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_cmd.wr) |=> (state == ST_IDLE));

    p_read_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_AWAIT && rsp_valid) |=> (state == ST_HOLD));

    p_busy_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_fire && state != ST_IDLE && !err_clr) |=> (err && $stable(req_cmd)));

    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !err_clr) |=> err);

    p_stray_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && state != ST_AWAIT) |=> $stable(rd_data));
endmodule

// File: rtl/cmdch_top.sv
module cmdch_top
    import cmdch_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 csr_we,
    input  logic [IDX_W-1:0]     csr_addr,
    input  logic [DATA_W-1:0]    csr_wdata,
    output logic [DATA_W-1:0]    csr_rdata,
    output logic                 bus_req_valid,
    input  logic                 bus_req_ready,
    output logic [CLS_W-1:0]     bus_req_cls,
    output logic                 bus_req_write,
    output logic [SID_W-1:0]     bus_req_sid,
    output logic [LEN_W-1:0]     bus_req_len,
    output logic [RADDR_W-1:0]   bus_req_addr,
    output logic [DATA_W-1:0]    bus_req_wdata,
    input  logic                 bus_rsp_valid,
    input  logic [DATA_W-1:0]    bus_rsp_rdata
);
    logic [DATA_W-1:0] wreg_d, wreg_q;
    logic              cmd_fire, vclr_fire, err_clr, cmd_legal;
    cmd_t              cmd_new, cmd_cur;
    logic [DATA_W-1:0] wd_trim, rsp_trim, rd_word, wd_bus;
    chan_state_e       state;
    logic              err;
    logic [DATA_W-1:0] status_word;

    always_comb begin
        cmd_fire  = csr_we && (csr_addr == IDX_CMD);
        vclr_fire = csr_we && (csr_addr == IDX_VCLR) && csr_wdata[0];
        err_clr   = csr_we && (csr_addr == IDX_STATUS) && csr_wdata[STS_ERR_BIT];
        wreg_d    = (csr_we && (csr_addr == IDX_WDATA)) ? csr_wdata : wreg_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wreg_q <= '0;
        end else begin
            wreg_q <= wreg_d;
        end
    end

    cmdch_unpack u_unpack (
        .word  (csr_wdata),
        .cmd   (cmd_new),
        .legal (cmd_legal)
    );

    cmdch_byte_mask u_wd_mask (
        .din    (wreg_q),
        .len_m1 (cmd_new.len_m1),
        .dout   (wd_trim)
    );

    cmdch_byte_mask u_rd_mask (
        .din    (bus_rsp_rdata),
        .len_m1 (cmd_cur.len_m1),
        .dout   (rsp_trim)
    );

    cmdch_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_fire  (cmd_fire),
        .cmd_in    (cmd_new),
        .cmd_legal (cmd_legal),
        .wd_in     (wd_trim),
        .vclr_fire (vclr_fire),
        .err_clr   (err_clr),
        .req_ready (bus_req_ready),
        .rsp_valid (bus_rsp_valid),
        .rsp_data  (rsp_trim),
        .state     (state),
        .err       (err),
        .req_valid (bus_req_valid),
        .req_cmd   (cmd_cur),
        .req_wdata (wd_bus),
        .rd_data   (rd_word)
    );

    always_comb begin
        status_word                        = '0;
        status_word[STS_ST_LSB +: ST_W]    = state;
        status_word[STS_ERR_BIT]           = err;
        unique case (csr_addr)
            IDX_STATUS: csr_rdata = status_word;
            IDX_WDATA:  csr_rdata = wreg_q;
            IDX_RDATA:  csr_rdata = rd_word;
            default:    csr_rdata = '0;
        endcase
    end

    assign bus_req_cls   = cmd_cur.cls;
    assign bus_req_write = cmd_cur.wr;
    assign bus_req_sid   = cmd_cur.sid;
    assign bus_req_len   = cmd_cur.len_m1;
    assign bus_req_addr  = cmd_cur.addr;
    assign bus_req_wdata = wd_bus;

    p_vclr_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vclr_fire && state == ST_HOLD) |=> (state == ST_IDLE));

    p_reject_rsvd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_fire && state == ST_IDLE && !cmd_legal) |=> (!bus_req_valid && err));

    p_rd_trim_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && cmd_cur.len_m1 == '0) |-> (rd_word[DATA_W-1:8] == '0));
endmodule

// File: tb/cmdch_top_bench.sv
module cmdch_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_we = 1'b0;
    logic [2:0]  csr_addr = 3'd0;
    logic [31:0] csr_wdata = 32'h0;
    logic [31:0] csr_rdata;
    logic        bus_req_valid;
    logic        bus_req_ready = 1'b0;
    logic [1:0]  bus_req_cls;
    logic        bus_req_write;
    logic [3:0]  bus_req_sid;
    logic [1:0]  bus_req_len;
    logic [15:0] bus_req_addr;
    logic [31:0] bus_req_wdata;
    logic        bus_rsp_valid = 1'b0;
    logic [31:0] bus_rsp_rdata = 32'h0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cmdch_top u_cmdch_top (.*);

    // cmd, wdata, response, expected bus wdata, expected read word
    localparam logic [159:0] VEC [6] = '{
        {32'h65001234, 32'hAABBCCDD, 32'h00000000, 32'h000000DD, 32'h00000000},
        {32'h2F0300FF, 32'h11223344, 32'h00000000, 32'h11223344, 32'h00000000},
        {32'h42010042, 32'h55555555, 32'hDEADBEEF, 32'h00005555, 32'h0000BEEF},
        {32'hCA02BEEF, 32'h00000000, 32'h89ABCDEF, 32'h00000000, 32'h00ABCDEF},
        {32'hE1028000, 32'hCAFEF00D, 32'h00000000, 32'h00FEF00D, 32'h00000000},
        {32'h40030000, 32'h00000000, 32'h01020304, 32'h00000000, 32'h01020304}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic csr_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic csr_read(input logic [2:0] a, output logic [31:0] d);
        csr_addr = a;
        #1;
        d = csr_rdata;
    endtask

    task automatic handshake();
        bus_req_ready = 1'b1;
        @(negedge clk);
        bus_req_ready = 1'b0;
    endtask

    task automatic respond(input logic [31:0] d);
        bus_rsp_valid = 1'b1; bus_rsp_rdata = d;
        @(negedge clk);
        bus_rsp_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, cmd, keep;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        csr_read(3'd0, v); chk("R1 reset status", v, 32'h0);
        csr_read(3'd2, v); chk("R1 reset rdata", v, 32'h0);
        chk("R1 reset req_valid", {31'h0, bus_req_valid}, 32'h0);

        for (int i = 0; i < 6; i++) begin
            cmd = VEC[i][159:128];
            csr_write(3'd1, VEC[i][127:96]);
            csr_write(3'd3, cmd);
            csr_read(3'd0, v); chk("R2 status issue", v, 32'h2);
            chk("R2 valid", {31'h0, bus_req_valid}, 32'h1);
            chk("R2 fields", {bus_req_cls, bus_req_write, 1'b0, bus_req_sid, 6'h0, bus_req_len, bus_req_addr},
                cmd & 32'hEF03FFFF);
            chk("R6 wdata", bus_req_wdata, VEC[i][63:32]);
            @(negedge clk);
            chk("R2 held", {31'h0, bus_req_valid}, 32'h1);
            handshake();
            if (cmd[29]) begin
                csr_read(3'd0, v); chk("R3 write done", v, 32'h0);
            end else begin
                csr_read(3'd0, v); chk("R4 await", v, 32'h4);
                respond(VEC[i][95:64]);
                csr_read(3'd0, v); chk("R4 hold", v, 32'hC);
                csr_read(3'd2, v); chk("R5 trimmed rdata", v, VEC[i][31:0]);
                csr_write(3'd4, 32'h1);
                csr_read(3'd0, v); chk("R7 cleared", v, 32'h0);
            end
        end

        // R8 command while busy, then abandoned read
        csr_write(3'd3, 32'h42010042);
        csr_write(3'd3, 32'h650077AA);
        csr_read(3'd0, v); chk("R8 busy error", v, 32'h12);
        chk("R8 fields kept", {16'h0, bus_req_addr}, 32'h0042);
        handshake();
        respond(32'hA5A5A5A5);
        csr_write(3'd3, 32'h65001111);
        csr_read(3'd0, v); chk("R8 hold cmd ignored", v, 32'h1C);
        chk("R8 no request", {31'h0, bus_req_valid}, 32'h0);
        csr_write(3'd0, 32'h10);
        csr_read(3'd0, v); chk("R10 err cleared", v, 32'hC);
        csr_write(3'd4, 32'h0);
        csr_read(3'd0, v); chk("R7 bit0 clear ignored", v, 32'hC);
        csr_write(3'd4, 32'h1);
        csr_read(3'd0, v); chk("R7 abandoned released", v, 32'h0);
        csr_write(3'd4, 32'h1);
        csr_read(3'd0, v); chk("R7 idle clear no effect", v, 32'h0);

        // R11 stray response
        csr_read(3'd2, keep);
        chk("R11 prior rdata", keep, 32'h0000A5A5);
        respond(32'h12345678);
        csr_read(3'd2, v); chk("R11 rdata unchanged", v, keep);
        csr_read(3'd0, v); chk("R11 state unchanged", v, 32'h0);

        // R9 reserved class and reserved bits
        csr_write(3'd3, 32'hA5001234);
        csr_read(3'd0, v); chk("R9 class2 rejected", v, 32'h10);
        chk("R9 no request", {31'h0, bus_req_valid}, 32'h0);
        csr_write(3'd0, 32'h10);
        csr_write(3'd3, 32'h65041234);
        csr_read(3'd0, v); chk("R9 rsv bits rejected", v, 32'h10);
        csr_write(3'd0, 32'h0);
        csr_read(3'd0, v); chk("R10 err kept", v, 32'h10);
        csr_write(3'd0, 32'h10);

        // R6 capture at command time
        csr_write(3'd1, 32'h01020304);
        csr_write(3'd3, 32'h2F030010);
        csr_write(3'd1, 32'hFFFFFFFF);
        chk("R6 captured wdata", bus_req_wdata, 32'h01020304);
        handshake();
        csr_read(3'd0, v); chk("R3 final idle", v, 32'h0);
        csr_read(3'd3, v); chk("R1 cmd reads zero", v, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule